// File: doc/BRIEF.md
# Shared bus driver sequencer

This block arbitrates the drive of a single-bit three-state party line that is shared by eight sources. A 3-bit source code names the source that should drive the line. The code is decoded into eight active-low driver enables, one per source. A group of three qualifying inputs gates the decoded enables: one input is active high and two are active low.

When the requested source changes, the block first releases every driver. It then waits a programmable number of clock cycles with the line undriven, and only after that enables the new source. The wait covers the gap between a driver's slowest release and the next driver's fastest turn-on, so two drivers never fight on the line. All timing is counted in whole clock cycles.

The block also contains a behavioural model of the line. The model reports the data of the enabled source, a flag that says whether any source drives the line, and a contention flag. The contention flag is raised if more than one enable is ever low.

Top module: `bus_drive_sequencer`

## Requirements
- R1: While a source is granted and the group is qualified, `drv_en_n` equals all ones except bit k = 0, where k is the granted 3-bit code, and `line_out` equals `src_data[k]`.
- R2: At no time is more than one bit of `drv_en_n` low.
- R3: Unless `grp_on` = 1, `grp_off_a_n` = 0 and `grp_off_b_n` = 0, all eight enables are 1 and `line_driven` is 0 in that same cycle, with no clock edge needed. The dead-time timing runs on regardless of the group inputs.
- R4: When a clock edge samples a `sel_code` that differs from the code currently held, every enable is 1 from that edge onward.
- R5: The newly selected enable goes low exactly DEAD_CYCLES clock edges after the edge that sampled the change (DEAD_CYCLES ≥ 1). During those cycles all enables stay 1.
- R6: A change sampled while a dead-time window is running restarts the window from its full length, and the window targets the newest code.
- R7: A `sel_code` that stays equal to the held code starts no window and leaves the enables unchanged.
- R8: When no enable is low, `line_driven` is 0 and `line_out` is high impedance. When one enable is low, `line_driven` is 1.
- R9: `contention` is 1 exactly when two or more enables are low, so it stays 0 in all operation.
- R10: The synchronous active-high reset `rst` sets every enable to 1 and clears the dead-time counter. The first edge after reset is released counts as a change, so the first grant appears DEAD_CYCLES edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_code | input | 3 | Requested source code |
| grp_on | input | 1 | Group qualifier, active high |
| grp_off_a_n | input | 1 | Group qualifier, active low |
| grp_off_b_n | input | 1 | Group qualifier, active low |
| src_data | input | 8 | Data bit each source would put on the line |
| drv_en_n | output | 8 | Per-source driver enables, active low |
| line_out | output | 1 | Modelled line value, high impedance when undriven |
| line_driven | output | 1 | 1 when some enable is low |
| contention | output | 1 | 1 when more than one enable is low |

## Verification
The group qualifiers and `src_data` act combinationally. Their effect on `drv_en_n`, `line_driven` and `line_out` is due in the same cycle. A select change acts on the edge that samples it, and the grant comes DEAD_CYCLES edges later. The bench drives inputs on the falling edge and advances its own timing model on the rising edge, counting edges since the last sampled change. It compares every output a short delay after each falling-edge drive, so each result is read in the cycle in which it falls due. Directed runs cover a change in mid-window, a repeated code, each group input on its own, and the first grant after reset, around a long seeded random run.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GAP   = 2'd1,
    PH_DRIVE = 2'd2
  } phase_e;

  // Group qualifier: active-high enable with two active-low enables.
  function automatic logic group_ok(input logic on_h, input logic off_a_n,
                                    input logic off_b_n);
    return on_h & ~off_a_n & ~off_b_n;
  endfunction

  // Count of asserted (low) enables in an active-low vector of up to 32 bits.
  function automatic int unsigned low_count(input logic [31:0] en_n,
                                            input int unsigned width);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < width; i++) begin
      if (!en_n[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/dead_time_ctrl.sv
module dead_time_ctrl
  import bus_seq_pkg::*;
#(
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned DEAD_CYCLES = 3,
  localparam int unsigned CNT_W      = $clog2(DEAD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_code,
  output logic [SEL_W-1:0] held_code,
  output logic             grant
);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             sel_change;   // sampled code differs from held one
  logic             last_tick;    // window ends on this edge

  assign sel_change = (phase == PH_IDLE) || (sel_code != held_code);
  assign last_tick  = (phase == PH_GAP) && (cnt == CNT_W'(1));
  assign grant      = (phase == PH_DRIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      held_code <= '0;
    end else if (sel_change) begin
      phase     <= PH_GAP;
      cnt       <= CNT_W'(DEAD_CYCLES);
      held_code <= sel_code;
    end else if (last_tick) begin
      phase <= PH_DRIVE;
      cnt   <= '0;
    end else if (phase == PH_GAP) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R4: a sampled change removes the grant on that edge
  a_r4_change_drops: assert property (@(posedge clk) disable iff (rst)
    sel_change |=> !grant);

  // R6: a change restarts the window at its full length
  a_r6_restart_full: assert property (@(posedge clk) disable iff (rst)
    sel_change |=> (cnt == CNT_W'(DEAD_CYCLES)) && (held_code == $past(sel_code)));

  // R5: the window counts down one per cycle while the code is steady
  a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP && !sel_change && !last_tick) |=> cnt == $past(cnt) - CNT_W'(1));

  // R7: a steady code keeps an existing grant
  a_r7_hold_grant: assert property (@(posedge clk) disable iff (rst)
    (grant && !sel_change) |=> grant && $stable(held_code));

endmodule

// File: rtl/enable_decoder.sv
module enable_decoder
  import bus_seq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic [SEL_W-1:0]   code,
  input  logic               grant,
  input  logic               grp_on,
  input  logic               grp_off_a_n,
  input  logic               grp_off_b_n,
  output logic [NUM_SRC-1:0] en_n
);

  logic qualified;
  assign qualified = grant & group_ok(grp_on, grp_off_a_n, grp_off_b_n);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
    assign en_n[g] = ~(qualified && (code == SEL_W'(g)));
  end

  // R3: a disqualified group forces every enable inactive
  always_comb begin
    a_r3_group_gate: assert (group_ok(grp_on, grp_off_a_n, grp_off_b_n) || (&en_n));
  end

endmodule

// File: rtl/line_model.sv
module line_model
  import bus_seq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] en_n,
  input  logic [NUM_SRC-1:0] data,
  output logic               driven,
  output logic               value,
  output logic               clash
);

  always_comb begin
    value = 1'b0;
    for (int unsigned i = 0; i < NUM_SRC; i++) begin
      if (!en_n[i]) value = value | data[i];
    end
  end

  assign driven = ~(&en_n);
  assign clash  = low_count(32'(en_n) | ~32'((64'd1 << NUM_SRC) - 1), NUM_SRC) > 1;

endmodule

// File: rtl/bus_drive_sequencer.sv
module bus_drive_sequencer
  import bus_seq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned DEAD_CYCLES = 3,
  localparam int unsigned SEL_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   sel_code,
  input  logic               grp_on,
  input  logic               grp_off_a_n,
  input  logic               grp_off_b_n,
  input  logic [NUM_SRC-1:0] src_data,
  output logic [NUM_SRC-1:0] drv_en_n,
  output logic               line_out,
  output logic               line_driven,
  output logic               contention
);

  logic [SEL_W-1:0] held_code;
  logic             grant;
  logic             line_val;

  dead_time_ctrl #(.SEL_W(SEL_W), .DEAD_CYCLES(DEAD_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .sel_code(sel_code),
    .held_code(held_code), .grant(grant)
  );

  enable_decoder #(.NUM_SRC(NUM_SRC)) u_dec (
    .code(held_code), .grant(grant), .grp_on(grp_on),
    .grp_off_a_n(grp_off_a_n), .grp_off_b_n(grp_off_b_n), .en_n(drv_en_n)
  );

  line_model #(.NUM_SRC(NUM_SRC)) u_line (
    .en_n(drv_en_n), .data(src_data), .driven(line_driven),
    .value(line_val), .clash(contention)
  );

  assign line_out = line_driven ? line_val : 1'bz;

  // R2: never more than one driver enabled
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~drv_en_n));

  // R9: the line model never reports a fight
  a_r9_no_clash: assert property (@(posedge clk) disable iff (rst)
    !contention);

  // R8: an undriven line reports itself undriven
  a_r8_float: assert property (@(posedge clk) disable iff (rst)
    (&drv_en_n) |-> !line_driven);

  // R10: reset leaves every enable inactive on the following cycle
  a_r10_reset_off: assert property (@(posedge clk)
    rst |=> (&drv_en_n));

endmodule

// File: tb/sim_bus_drive_sequencer.sv
`timescale 1ns/1ps
module sim_bus_drive_sequencer;

  localparam int unsigned NS   = 8;
  localparam int unsigned DEAD = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    sel_code = 3'd0;
  logic          grp_on = 1'b1, grp_off_a_n = 1'b0, grp_off_b_n = 1'b0;
  logic [NS-1:0] src_data = '0;
  logic [NS-1:0] drv_en_n;
  logic          line_out, line_driven, contention;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 0;

  // bench timing model: edges since the last sampled change
  bit          m_started;
  int unsigned m_since;
  logic [2:0]  m_code;
  bit          m_restart;

  always #5 clk = ~clk;

  bus_drive_sequencer #(.NUM_SRC(NS), .DEAD_CYCLES(DEAD)) u0 (
    .clk(clk), .rst(rst), .sel_code(sel_code), .grp_on(grp_on),
    .grp_off_a_n(grp_off_a_n), .grp_off_b_n(grp_off_b_n), .src_data(src_data),
    .drv_en_n(drv_en_n), .line_out(line_out), .line_driven(line_driven),
    .contention(contention)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_started <= 0; m_since <= 0; m_code <= 3'd0; m_restart <= 0;
    end else if (!m_started || sel_code != m_code) begin
      m_restart <= m_started && m_since < DEAD;
      m_started <= 1; m_since <= 0; m_code <= sel_code;
    end else if (m_since < 1000) begin
      m_since <= m_since + 1;
    end
  end

  function automatic bit qual_ok();
    return grp_on && !grp_off_a_n && !grp_off_b_n;
  endfunction

  function automatic logic [NS-1:0] exp_en();
    if (m_started && m_since >= DEAD && qual_ok()) return ~(NS'(1) << m_code);
    return '1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string en_tag();
    if (!qual_ok())        return "R3 group gate";
    if (!m_started)        return "R10 reset state";
    if (m_since == 0)      return "R4 change drops enables";
    if (m_since < DEAD)    return m_restart ? "R6 window restart" : "R5 dead time";
    if (m_since == DEAD)   return "R5 grant after dead time";
    return "R1 R7 steady decode";
  endfunction

  task automatic check_all();
    logic [NS-1:0] e;
    int unsigned lows;
    e = exp_en();
    chk(en_tag(), 32'(drv_en_n), 32'(e));
    lows = 0;
    for (int i = 0; i < NS; i++) if (!drv_en_n[i]) lows++;
    chk("R2 at most one low", 32'(lows <= 1), 32'd1);
    chk("R8 line driven flag", 32'(line_driven), 32'(e != '1));
    if (e != '1) chk("R1 line data", 32'(line_out), 32'(src_data[m_code]));
    chk("R9 contention", 32'(contention), 32'd0);
  endtask

  task automatic step();
    @(negedge clk); #1; check_all();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk("R10 enables off in reset", 32'(drv_en_n), 32'hFF);
    chk("R10 line floats in reset", 32'(line_driven), 32'd0);
    @(negedge clk); rst = 0; sel_code = 3'd5; src_data = 8'hA5;
    #1; check_all();
    // R10 first grant after DEAD edges
    repeat (DEAD + 2) step();
    chk("R1 enable for code 5", 32'(drv_en_n), 32'hDF);
    // R7 same code rewritten: no gap
    repeat (4) begin @(negedge clk); sel_code = 3'd5; #1; check_all(); end
    chk("R7 steady code keeps grant", 32'(drv_en_n), 32'hDF);
    // R6 change mid-window
    @(negedge clk); sel_code = 3'd2; #1; check_all();
    step();
    @(negedge clk); sel_code = 3'd7; #1; check_all();
    repeat (DEAD + 1) step();
    chk("R6 newest code granted", 32'(drv_en_n), 32'h7F);
    // R3 each group input alone
    @(negedge clk); grp_on = 0; #1; check_all();
    chk("R3 grp_on low", 32'(drv_en_n), 32'hFF);
    @(negedge clk); grp_on = 1; grp_off_a_n = 1; #1; check_all();
    chk("R3 grp_off_a_n high", 32'(line_driven), 32'd0);
    @(negedge clk); grp_off_a_n = 0; grp_off_b_n = 1; #1; check_all();
    chk("R3 grp_off_b_n high", 32'(drv_en_n), 32'hFF);
    @(negedge clk); grp_off_b_n = 0; #1; check_all();
    chk("R3 group restored", 32'(drv_en_n), 32'h7F);
    // R1 line follows data
    @(negedge clk); src_data = 8'h80; #1; check_all();
    chk("R1 line high", 32'(line_out), 32'd1);
    @(negedge clk); src_data = 8'h7F; #1; check_all();
    chk("R1 line low", 32'(line_out), 32'd0);
    // random run
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(99) < 20) sel_code = 3'($urandom_range(7));
      grp_on      = $urandom_range(99) < 95;
      grp_off_a_n = $urandom_range(99) < 4;
      grp_off_b_n = $urandom_range(99) < 4;
      src_data    = 8'($urandom);
      if ($urandom_range(999) == 0) rst = 1; else rst = 0;
      #1;
      if (!rst) check_all();
    end
    // R10 reset mid-grant
    @(negedge clk); rst = 1; @(negedge clk); #1;
    chk("R10 reset clears grant", 32'(drv_en_n), 32'hFF);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule